// File: doc/BRIEF.md
# Unsigned Binary to Decimal Text Converter

This block takes an unsigned binary word and renders it as a zero-terminated string of decimal ASCII characters in a small byte buffer that sits outside the block. A one-cycle start strobe captures the word. The block then writes the bytes one at a time through a plain write port that carries an address, a data byte and an enable. The terminator goes in first, at the top slot of the buffer. The digits follow in falling address order, the least significant digit first.

Each digit comes from one pass of an iterative divide-by-ten unit. The remainder becomes the character and the quotient becomes the value for the next pass. The conversion stops once a pass leaves a zero quotient. On the same cycle as the final digit write, the block raises a one-cycle completion pulse and presents the buffer index where the string begins. The consumer reads the text from that index up to the terminator. The divider retires a parameterised number of dividend bits per clock, which sets the fixed time each digit takes.

Top module: `dec_text_conv`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_en_o`, `done_o` and `busy_o` are all low.
- R2: The first write of every conversion puts the byte 0x00 at index BUF_LEN-1 (11 by default). It occurs in the cycle after the start strobe is sampled.
- R3: Each later write carries 0x30 plus the remainder of the current value divided by ten, so every digit byte lies in 0x30..0x39. Each write goes to the index one below the previous write.
- R4: The digit sequence ends with the write whose division leaves a zero quotient. For example, 2037 writes '7','3','0','2' at indices 10, 9, 8 and 7.
- R5: An input of zero writes exactly one digit, '0', at index 10, and reports index 10.
- R6: The input 4294967295 writes ten digits at indices 10 down to 1. Index 0 is never written.
- R7: `done_o` is high for exactly one cycle. That cycle is the cycle of the final digit write, and `first_idx_o` then equals that write's address.
- R8: A start strobe that arrives while `busy_o` is high, including the `done_o` cycle, has no effect on the writes that follow. `busy_o` is low in the next cycle.
- R9: Every digit takes VAL_W/STEP+1 cycles, which is 9 by default. With the start sampled at edge 0, the final digit write of an N-digit result falls in the cycle after edge 9*N.
- R10: `busy_o` is high from the terminator write through the `done_o` cycle, and low in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| value_i | input | VAL_W | Unsigned word to convert |
| wr_en_o | output | 1 | Byte write enable |
| wr_addr_o | output | AW | Byte write index into the buffer |
| wr_data_o | output | 8 | Byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| first_idx_o | output | AW | Index of the most significant digit, valid with done_o |
| busy_o | output | 1 | Conversion in progress |

## Verification
Two events can share a cycle. The final digit write and the completion pulse always coincide, and a new start strobe can also land in that same cycle. A scoreboard holds every expected byte write, and the item for the last digit carries a flag. In the cycle of that write the monitor requires `done_o` and checks `first_idx_o` against the write address. In one test the driver raises the start strobe in the very cycle `done_o` is seen. That strobe must be ignored: `busy_o` must stay low in the following cycles, and the monitor must see no write that has no expected item in the queue.

// File: rtl/dec_text_pkg.sv
package dec_text_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_TERM = 2'd1,
      ST_DIV  = 2'd2
   } conv_state_e;

   // upper bound on decimal digits of a w-bit unsigned value (log10(2) ~ 0.30103)
   function automatic int dec_digits(input int w);
      return (w * 30103 + 99999) / 100000;
   endfunction

endpackage

// File: rtl/dec_text_div10.sv
module dec_text_div10 #(
   parameter int VAL_W = 32,
   parameter int STEP  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [VAL_W-1:0] arg_i,
   output logic             done_o,
   output logic [VAL_W-1:0] quot_o,
   output logic [3:0]       rem_o
);
   localparam int STEPS = VAL_W / STEP;
   localparam int CW    = $clog2(STEPS + 1);

   if (VAL_W % STEP != 0) begin : g_bad_step
      $error("VAL_W must be a multiple of STEP");
   end
   if (STEP < 1 || STEP > VAL_W) begin : g_bad_range
      $error("STEP out of range");
   end

   logic [VAL_W-1:0] work_q, work_n;
   logic [3:0]       rem_q, rem_n;
   logic [CW-1:0]    cnt_q;
   logic             done_q;
   logic [4:0]       trial;

   // restoring division by ten, STEP dividend bits per clock
   always_comb begin
      work_n = work_q;
      rem_n  = rem_q;
      trial  = '0;
      for (int i = 0; i < STEP; i++) begin
         trial  = {rem_n, work_n[VAL_W-1]};
         work_n = {work_n[VAL_W-2:0], 1'b0};
         if (trial >= 5'd10) begin
            rem_n     = 4'(trial - 5'd10);
            work_n[0] = 1'b1;
         end else begin
            rem_n = trial[3:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
         rem_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go_i) begin
            work_q <= arg_i;
            rem_q  <= '0;
            cnt_q  <= CW'(STEPS);
         end else if (cnt_q != '0) begin
            work_q <= work_n;
            rem_q  <= rem_n;
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) done_q <= 1'b1;
         end
      end
   end

   assign done_o = done_q;
   assign quot_o = work_q;
   assign rem_o  = rem_q;

   p_rem_below_ten_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (rem_o < 4'd10));

   p_done_single_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/dec_text_seq.sv
module dec_text_seq
   import dec_text_pkg::*;
#(
   parameter int VAL_W   = 32,
   parameter int BUF_LEN = 12,
   parameter int STEP    = 4,
   parameter int AW      = $clog2(BUF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VAL_W-1:0] value_i,
   input  logic             div_done_i,
   input  logic [VAL_W-1:0] div_quot_i,
   input  logic [3:0]       div_rem_i,
   output logic             div_go_o,
   output logic [VAL_W-1:0] div_arg_o,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [7:0]       wr_data_o,
   output logic             done_o,
   output logic [AW-1:0]    first_idx_o,
   output logic             busy_o
);
   localparam int         STEPS   = VAL_W / STEP;
   localparam int         LW      = $clog2(STEPS + 2);
   localparam int         DIG_MAX = dec_digits(VAL_W);
   localparam logic [AW-1:0] LAST = AW'(BUF_LEN - 1);

   conv_state_e      state_q;
   logic [AW-1:0]    ptr_q;
   logic [VAL_W-1:0] val_q;
   logic             quot_zero;

   assign quot_zero = (div_quot_i == '0);

   always_comb begin
      div_go_o    = 1'b0;
      div_arg_o   = val_q;
      wr_en_o     = 1'b0;
      wr_addr_o   = LAST;
      wr_data_o   = 8'h00;
      done_o      = 1'b0;
      first_idx_o = ptr_q;
      case (state_q)
         ST_TERM: begin
            wr_en_o  = 1'b1;
            div_go_o = 1'b1;
         end
         ST_DIV: begin
            if (div_done_i) begin
               wr_en_o   = 1'b1;
               wr_addr_o = ptr_q;
               wr_data_o = 8'h30 + {4'h0, div_rem_i};
               if (quot_zero) begin
                  done_o = 1'b1;
               end else begin
                  div_go_o  = 1'b1;
                  div_arg_o = div_quot_i;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= LAST;
         val_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               val_q   <= value_i;
               state_q <= ST_TERM;
            end
            ST_TERM: begin
               ptr_q   <= LAST - 1'b1;
               state_q <= ST_DIV;
            end
            ST_DIV: if (div_done_i) begin
               if (quot_zero) state_q <= ST_IDLE;
               else           ptr_q   <= ptr_q - 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   // cycles since the last divider launch, for the latency bound
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lat_q <= '0;
      else if (div_go_o)                          lat_q <= '0;
      else if (state_q == ST_DIV && lat_q <= LW'(STEPS)) lat_q <= lat_q + 1'b1;
   end

   p_term_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (wr_en_o && wr_addr_o == LAST && wr_data_o == 8'h00));

   p_digit_ascii_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !$rose(busy_o)) |-> (wr_data_o >= 8'h30 && wr_data_o <= 8'h39));

   p_index_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (int'(wr_addr_o) >= BUF_LEN - 1 - DIG_MAX));

   p_done_with_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (wr_en_o && first_idx_o == wr_addr_o));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   p_digit_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DIV) |-> (lat_q <= LW'(STEPS)));

endmodule

// File: rtl/dec_text_conv.sv
module dec_text_conv
   import dec_text_pkg::*;
#(
   parameter int VAL_W   = 32,
   parameter int BUF_LEN = 12,
   parameter int STEP    = 4,
   parameter int AW      = $clog2(BUF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VAL_W-1:0] value_i,
   output logic             wr_en_o,
   output logic [AW-1:0]    wr_addr_o,
   output logic [7:0]       wr_data_o,
   output logic             done_o,
   output logic [AW-1:0]    first_idx_o,
   output logic             busy_o
);
   localparam int DIG_MAX = dec_digits(VAL_W);

   if (BUF_LEN < DIG_MAX + 1) begin : g_short_buf
      $error("buffer cannot hold the widest value plus terminator");
   end
   if (AW < $clog2(BUF_LEN)) begin : g_narrow_addr
      $error("AW too narrow for BUF_LEN");
   end

   logic             div_go, div_done;
   logic [VAL_W-1:0] div_arg, div_quot;
   logic [3:0]       div_rem;

   dec_text_div10 #(.VAL_W(VAL_W), .STEP(STEP)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .arg_i  (div_arg),
      .done_o (div_done),
      .quot_o (div_quot),
      .rem_o  (div_rem)
   );

   dec_text_seq #(.VAL_W(VAL_W), .BUF_LEN(BUF_LEN), .STEP(STEP), .AW(AW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .value_i     (value_i),
      .div_done_i  (div_done),
      .div_quot_i  (div_quot),
      .div_rem_i   (div_rem),
      .div_go_o    (div_go),
      .div_arg_o   (div_arg),
      .wr_en_o     (wr_en_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o),
      .done_o      (done_o),
      .first_idx_o (first_idx_o),
      .busy_o      (busy_o)
   );

endmodule

// File: tb/test_dec_text_conv.sv
module test_dec_text_conv;
   localparam int CLK_PERIOD = 10;
   localparam int PER_DIGIT  = 32 / 4 + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] value_i = '0;
   logic        wr_en_o, done_o, busy_o;
   logic [3:0]  wr_addr_o, first_idx_o;
   logic [7:0]  wr_data_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dec_text_conv i_dec_text_conv (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .value_i(value_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .done_o(done_o), .first_idx_o(first_idx_o), .busy_o(busy_o)
   );

   typedef struct {
      logic [3:0] a;
      logic [7:0] d;
      bit         last;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   saw_idx0 = 0;
   bit   finished = 0;

   task automatic chk(input bit ok, input string tag, input string msg);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s", tag, msg);
      end
   endtask

   // monitor: pops expected writes and judges done/first index in the same cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en_o) begin
            if (wr_addr_o == 4'd0) saw_idx0 = 1;
            if (q.size() == 0) begin
               chk(0, "R8", $sformatf("unexpected write got addr=%0d data=%h exp none",
                   wr_addr_o, wr_data_o));
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(wr_addr_o == e.a && wr_data_o == e.d, (e.d == 8'h00) ? "R2" : "R3",
                   $sformatf("write got %0d/%h exp %0d/%h", wr_addr_o, wr_data_o, e.a, e.d));
               chk(done_o == e.last, "R7",
                   $sformatf("done got %0b exp %0b", done_o, e.last));
               if (e.last && done_o)
                  chk(first_idx_o == e.a, "R7",
                      $sformatf("first index got %0d exp %0d", first_idx_o, e.a));
            end
         end else if (done_o) begin
            chk(0, "R7", "done got 1 exp 0 (no write)");
         end
      end
   end

   // driver: queues expected bytes, starts a conversion, optionally pokes start while busy
   task automatic run(input logic [31:0] v, input int poke_mid, input bit poke_done,
                      input string tag);
      logic [31:0] t;
      logic [3:0]  p;
      int          nd;
      int          cyc;
      t  = v;
      p  = 4'd10;
      nd = 0;
      q.push_back('{a: 4'd11, d: 8'h00, last: 0});
      do begin
         q.push_back('{a: p, d: 8'h30 + 8'(t % 10), last: (t / 10 == 0)});
         t = t / 10;
         p = p - 1'b1;
         nd++;
      end while (t != 0);
      @(negedge clk);
      start_i = 1'b1;
      value_i = v;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      while (!done_o && cyc < 400) begin
         start_i = (cyc == poke_mid);
         value_i = ~v;
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      chk(cyc == 1 + PER_DIGIT * nd, "R9",
          $sformatf("%s last digit cycle got %0d exp %0d", tag, cyc, 1 + PER_DIGIT * nd));
      if (poke_done) begin
         start_i = 1'b1;
         value_i = 32'd7;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(!busy_o, poke_done ? "R8" : "R10", $sformatf("%s busy after done got %0b exp 0", tag, busy_o));
      repeat (3) @(negedge clk);
      chk(!busy_o && q.size() == 0, "R4",
          $sformatf("%s idle/pending got busy=%0b left=%0d exp 0/0", tag, busy_o, q.size()));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!wr_en_o && !done_o && !busy_o, "R1",
          $sformatf("in reset got en=%0b done=%0b busy=%0b exp 0", wr_en_o, done_o, busy_o));
      rst_n = 1'b1;
      @(negedge clk);
      chk(!wr_en_o && !done_o && !busy_o, "R1",
          $sformatf("after reset got en=%0b done=%0b busy=%0b exp 0", wr_en_o, done_o, busy_o));
      run(32'd2037, 0, 0, "R4 2037");
      run(32'd0, 0, 0, "R5 zero");
      saw_idx0 = 0;
      run(32'hFFFF_FFFF, 0, 0, "R6 max");
      chk(!saw_idx0, "R6", $sformatf("index 0 written got %0b exp 0", saw_idx0));
      run(32'd9, 0, 0, "R3 nine");
      run(32'd10, 0, 0, "R3 ten");
      run(32'd100, 5, 0, "R8 mid poke");
      run(32'd1234567, 30, 1, "R8 done poke");
      chk(busy_o == 1'b0, "R10", $sformatf("final busy got %0b exp 0", busy_o));
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule